// File: doc/BRIEF.md
# Two-Bit Branch Direction Predictor

This block predicts whether a conditional branch will be taken. A table of two-bit saturating counters is addressed by a slice of the fetch address. The lookup side is purely combinational: the prediction for `lk_pc` appears in the same cycle. The update side takes the resolved branch's address and its real direction, and moves the addressed counter one step towards that direction at the next clock edge.

The table stores no tags. Two branches whose addresses agree in the index slice share one counter and disturb each other. Because the prediction comes from the upper counter bit, a strongly biased entry needs two wrong outcomes in a row before it changes its answer. For a loop branch, the single not-taken exit therefore does not spoil the prediction for the next run of the loop. The table depth, address width and number of dropped alignment bits are parameters.

Top module: `bht_predictor`

## Requirements
- R1: After reset every counter holds 1 (weakly not taken), so every lookup returns counter 1 and a not-taken prediction.
- R2: The entry is selected by address bits [DROP_BITS+IDX_W-1 : DROP_BITS], with IDX_W = log2(DEPTH). Lower and higher address bits are ignored, so addresses that differ only there alias onto one entry.
- R3: An accepted update increments the addressed counter on a taken outcome and decrements it on a not-taken outcome.
- R4: The counter saturates: taken at 3 stays 3, and not-taken at 0 stays 0.
- R5: The counter encoding is 0 strong not taken, 1 weak not taken, 2 weak taken and 3 strong taken. The prediction is the counter's upper bit.
- R6: From a strong state, one opposite outcome leaves the prediction unchanged, and a second consecutive opposite outcome flips it.
- R7: The lookup is combinational. When an update and a lookup address the same entry in one cycle, the lookup returns the old counter, and the new value is visible from the next cycle.
- R8: While `up_valid` is low, `up_pc` and `up_taken` have no effect on any counter.
- R9: For a loop branch taken N-1 times and then not taken once, each repeat of the loop after the first costs exactly one misprediction.
- R10: An update changes only the addressed entry. All other entries keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_pc | input | PC_W | Fetch address to predict |
| lk_taken | output | 1 | Predicted direction (1 = taken) |
| lk_ctr | output | 2 | Counter state of the looked-up entry |
| up_valid | input | 1 | Update strobe for a resolved branch |
| up_pc | input | PC_W | Address of the resolved branch |
| up_taken | input | 1 | Actual outcome of the resolved branch |

## Verification
The bench drives counters to both ends of the range. A design that wraps instead of saturating would predict the wrong way after one more step. It walks a strong entry down by one step to show that the prediction holds, where a one-bit-style design would flip at once. It also runs a repeated loop pattern and counts mispredictions, which would come out as two per run without hysteresis. Other tests exercise aliasing through high and low address bits, a wrong index slice that would miss the shared entry, a same-cycle update and lookup that must show the old value, and updates with the strobe low that must leave the table untouched.

// File: rtl/bht_pkg.sv
package bht_pkg;

   typedef logic [1:0] ctr_t;

   localparam ctr_t CTR_STRONG_NT = 2'd0;
   localparam ctr_t CTR_WEAK_NT   = 2'd1;
   localparam ctr_t CTR_WEAK_T    = 2'd2;
   localparam ctr_t CTR_STRONG_T  = 2'd3;

   // one saturating step towards the observed outcome
   function automatic ctr_t ctr_step(input ctr_t cur, input logic taken);
      ctr_t nxt;
      if (taken) nxt = (cur == CTR_STRONG_T)  ? cur : cur + 2'd1;
      else       nxt = (cur == CTR_STRONG_NT) ? cur : cur - 2'd1;
      return nxt;
   endfunction

endpackage

// File: rtl/bht_index.sv
module bht_index #(
   parameter int PC_W      = 32,
   parameter int IDX_W     = 6,
   parameter int DROP_BITS = 2
) (
   input  logic [PC_W-1:0]  pc,
   output logic [IDX_W-1:0] idx
);
   generate
      if (DROP_BITS == 0) begin : g_nodrop
         assign idx = pc[IDX_W-1:0];
      end else begin : g_drop
         // alignment bits below DROP_BITS carry no branch identity
         assign idx = pc[DROP_BITS +: IDX_W];
      end
   endgenerate
endmodule

// File: rtl/bht_ctr_cell.sv
module bht_ctr_cell
   import bht_pkg::*;
#(
   parameter ctr_t INIT = CTR_WEAK_NT
) (
   input  logic clk,
   input  logic rst_n,
   input  logic wr_en,
   input  logic taken,
   output ctr_t ctr
);
   always_ff @(posedge clk) begin
      if (!rst_n)     ctr <= INIT;
      else if (wr_en) ctr <= ctr_step(ctr, taken);
   end
endmodule

// File: rtl/bht_rd_mux.sv
module bht_rd_mux
   import bht_pkg::*;
#(
   parameter int DEPTH = 64,
   parameter int IDX_W = 6
) (
   input  ctr_t             entries [DEPTH],
   input  logic [IDX_W-1:0] sel,
   output ctr_t             dout
);
   always_comb begin
      dout = entries[sel];
   end
endmodule

// File: rtl/bht_predictor.sv
module bht_predictor
   import bht_pkg::*;
#(
   parameter int PC_W      = 32,
   parameter int DEPTH     = 64,
   parameter int DROP_BITS = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [PC_W-1:0] lk_pc,
   output logic            lk_taken,
   output logic [1:0]      lk_ctr,
   input  logic            up_valid,
   input  logic [PC_W-1:0] up_pc,
   input  logic            up_taken
);
   localparam int IDX_W = $clog2(DEPTH);

   generate
      if (DEPTH < 2 || (1 << IDX_W) != DEPTH) begin : g_bad_depth
         $error("bht_predictor: DEPTH must be a power of two of at least 2");
      end
      if (PC_W < IDX_W + DROP_BITS) begin : g_bad_pcw
         $error("bht_predictor: PC_W too narrow for index and dropped bits");
      end
   endgenerate

   logic [IDX_W-1:0] rd_idx;
   logic [IDX_W-1:0] wr_idx;
   ctr_t             cells [DEPTH];
   ctr_t             rd_ctr;

   bht_index #(.PC_W(PC_W), .IDX_W(IDX_W), .DROP_BITS(DROP_BITS)) u_rd_index (
      .pc  (lk_pc),
      .idx (rd_idx)
   );

   bht_index #(.PC_W(PC_W), .IDX_W(IDX_W), .DROP_BITS(DROP_BITS)) u_wr_index (
      .pc  (up_pc),
      .idx (wr_idx)
   );

   generate
      for (genvar e = 0; e < DEPTH; e++) begin : g_entry
         logic hit;
         assign hit = up_valid && (wr_idx == IDX_W'(e));
         bht_ctr_cell #(.INIT(CTR_WEAK_NT)) u_cell (
            .clk   (clk),
            .rst_n (rst_n),
            .wr_en (hit),
            .taken (up_taken),
            .ctr   (cells[e])
         );
      end
   endgenerate

   bht_rd_mux #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_rd_mux (
      .entries (cells),
      .sel     (rd_idx),
      .dout    (rd_ctr)
   );

   assign lk_ctr   = rd_ctr;
   assign lk_taken = rd_ctr[1];

endmodule

// File: rtl/bht_predictor_chk.sv
module bht_predictor_chk #(
   parameter int PC_W = 32
) (
   input logic            clk,
   input logic            rst_n,
   input logic [PC_W-1:0] lk_pc,
   input logic            lk_taken,
   input logic [1:0]      lk_ctr,
   input logic            up_valid,
   input logic [PC_W-1:0] up_pc,
   input logic            up_taken
);
   logic same_pc;
   assign same_pc = up_valid && (up_pc == lk_pc);

   // R3: a watched entry moves one step in the outcome's direction
   p_step_up_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (same_pc && up_taken && lk_ctr != 2'd3) ##1 $stable(lk_pc)
         |-> lk_ctr == $past(lk_ctr) + 2'd1);

   p_step_dn_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (same_pc && !up_taken && lk_ctr != 2'd0) ##1 $stable(lk_pc)
         |-> lk_ctr == $past(lk_ctr) - 2'd1);

   // R4: saturation at both ends
   p_sat_top_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (same_pc && up_taken && lk_ctr == 2'd3) ##1 $stable(lk_pc) |-> lk_ctr == 2'd3);

   p_sat_bot_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (same_pc && !up_taken && lk_ctr == 2'd0) ##1 $stable(lk_pc) |-> lk_ctr == 2'd0);

   // R6: one opposite outcome from a strong state keeps the prediction
   p_hyst_t_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (same_pc && !up_taken && lk_ctr == 2'd3) ##1 $stable(lk_pc) |-> lk_taken);

   p_hyst_nt_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (same_pc && up_taken && lk_ctr == 2'd0) ##1 $stable(lk_pc) |-> !lk_taken);

   // R8: without an update strobe a watched entry keeps its value
   p_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !up_valid ##1 $stable(lk_pc) |-> $stable(lk_ctr));
endmodule

bind bht_predictor bht_predictor_chk #(.PC_W(PC_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .lk_pc    (lk_pc),
   .lk_taken (lk_taken),
   .lk_ctr   (lk_ctr),
   .up_valid (up_valid),
   .up_pc    (up_pc),
   .up_taken (up_taken)
);

// File: tb/bht_predictor_bench.sv
module bht_predictor_bench;
   localparam int PC_W = 32;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [PC_W-1:0] lk_pc = '0;
   logic            lk_taken;
   logic [1:0]      lk_ctr;
   logic            up_valid = 1'b0;
   logic [PC_W-1:0] up_pc = '0;
   logic            up_taken = 1'b0;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   bht_predictor u_bht_predictor (
      .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_taken(lk_taken),
      .lk_ctr(lk_ctr), .up_valid(up_valid), .up_pc(up_pc), .up_taken(up_taken)
   );

   task automatic chk(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // drive at a falling edge, commit at the rising edge, release after
   task automatic upd(input logic [PC_W-1:0] pc, input logic t);
      @(negedge clk);
      up_valid = 1'b1; up_pc = pc; up_taken = t;
      @(negedge clk);
      up_valid = 1'b0;
   endtask

   task automatic look(input logic [PC_W-1:0] pc, input string req,
                       input int exp_ctr);
      lk_pc = pc;
      #1;
      chk({req, " ctr"}, int'(lk_ctr), exp_ctr);
      chk({req, " pred"}, int'(lk_taken), exp_ctr / 2);
   endtask

   task automatic t_reset;
      for (int i = 0; i < 64; i += 9) look(PC_W'(i * 4), "R1 reset entry", 1);
   endtask

   task automatic t_count;
      logic [PC_W-1:0] a = 32'h0000_0040;
      upd(a, 1); look(a, "R3 inc", 2);
      upd(a, 1); look(a, "R3 inc", 3);
      upd(a, 1); look(a, "R4 top sat", 3);
      upd(a, 0); look(a, "R3 dec", 2);
      upd(a, 0); look(a, "R5 weak nt", 1);
      upd(a, 0); look(a, "R3 dec", 0);
      upd(a, 0); look(a, "R4 bottom sat", 0);
   endtask

   task automatic t_hyst;
      logic [PC_W-1:0] a = 32'h0000_0080;
      upd(a, 1); upd(a, 1);
      upd(a, 0); look(a, "R6 first miss keeps taken", 2);
      upd(a, 0); look(a, "R6 second miss flips", 1);
      upd(a, 0); upd(a, 1); look(a, "R6 strong nt one taken keeps nt", 1);
   endtask

   task automatic t_alias;
      logic [PC_W-1:0] b = 32'h0000_00C0;
      upd(b + 32'd256, 1);
      look(b, "R2 high bits alias", 2);
      upd(b + 32'd3, 1);
      look(b, "R2 low bits ignored", 3);
      look(b + 32'd4, "R10 neighbour untouched", 1);
      look(b - 32'd4, "R10 neighbour untouched", 1);
   endtask

   task automatic t_same_cycle;
      logic [PC_W-1:0] c = 32'h0000_0010;
      @(negedge clk);
      lk_pc = c; up_valid = 1'b1; up_pc = c; up_taken = 1'b1;
      #1;
      chk("R7 same-cycle old value", int'(lk_ctr), 1);
      @(posedge clk); #1;
      up_valid = 1'b0;
      chk("R7 new value next cycle", int'(lk_ctr), 2);
   endtask

   task automatic t_ignore;
      logic [PC_W-1:0] d = 32'h0000_0020;
      @(negedge clk);
      lk_pc = d; up_valid = 1'b0; up_pc = d; up_taken = 1'b1;
      repeat (3) @(negedge clk);
      up_taken = 1'b0;
      repeat (2) @(negedge clk);
      look(d, "R8 no strobe no change", 1);
   endtask

   task automatic t_loop;
      logic [PC_W-1:0] l = 32'h0000_0100;
      for (int run = 0; run < 3; run++) begin
         int miss = 0;
         for (int it = 0; it < 5; it++) begin
            logic outcome = (it < 4);
            lk_pc = l; #1;
            if (lk_taken != outcome) miss++;
            upd(l, outcome);
         end
         if (run > 0) chk("R9 one miss per loop run", miss, 1);
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_count();
      t_hyst();
      t_alias();
      t_same_cycle();
      t_ignore();
      t_loop();
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule